// File: doc/BRIEF.md
# Dynamic Bus Voltage Reference Generator

This block produces the reference command for the regulator of a converter that feeds one shared bus. The bus supplies several parallel LED strings, and each string has its own current sink. A phase-shifted dimming modulator decides which strings conduct. This block receives that on/off schedule a fixed number of clocks before it takes effect. It then picks the highest voltage group code among the strings that are conducting now or will start within that window. The regulator can therefore raise the bus before a demanding string switches on. The bus stays at the lowest level that keeps every conducting sink in regulation, and it does not sit at a fixed worst-case setpoint.

Each string's required voltage is given as a small group code, not an exact value. A calibration sweep fills in these codes elsewhere. Strings that have been flagged as failed take no part in the maximum. A programmable floor code is a lower bound for the output, and the output falls to it when nothing is demanded. A fixed mode ignores the schedule and holds the reference at the highest code among the healthy strings. The block also delays the schedule internally and outputs it as the mask that actually drives the string switches, so the two stay aligned.

Top module: `busref_gen`

## Requirements
- R1: While rst_n is low, ref_code and str_on are both zero, whatever the other inputs are.
- R2: str_on equals the value that sched_mask held LOOKAHEAD rising edges earlier. Bit i is string i, and a set bit means the string conducts. Samples taken before reset released count as zero.
- R3: In tracking mode (fixed_mode = 0), ref_code after an edge equals the larger of floor_code and the highest group code among non-failed strings. A string counts if its bit is set in sched_mask sampled at that edge or in any of the LOOKAHEAD samples before it.
- R4: Whenever the group codes and fail mask are steady, ref_code is never below the group code of any non-failed string shown on str_on.
- R5: When a single string is the only one scheduled for LOOKAHEAD+1 consecutive samples, ref_code equals the larger of floor_code and that string's code.
- R6: When every string is scheduled on continuously, ref_code stays constant at the highest code among the non-failed strings.
- R7: When the set of demanded strings is empty, ref_code after the next edge equals floor_code.
- R8: A string whose fail_mask bit is 1 never contributes its code, in either mode.
- R9: In fixed mode (fixed_mode = 1), ref_code equals the larger of floor_code and the highest code among non-failed strings, whatever sched_mask is.
- R10: ref_code is never below the floor_code value sampled at the edge that produced it.
- R11: The group code of string i sits at grp_codes[i*GRP_W +: GRP_W]. It is an unsigned number, and a larger value means a higher bus voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_mask | input | NUM_STR | On/off schedule that takes effect LOOKAHEAD clocks later |
| grp_codes | input | NUM_STR*GRP_W | Packed per-string voltage group codes |
| fail_mask | input | NUM_STR | Strings excluded as failed |
| floor_code | input | GRP_W | Minimum reference code |
| fixed_mode | input | 1 | 1 = hold the reference at the healthy maximum |
| str_on | output | NUM_STR | Delayed schedule that drives the string switches |
| ref_code | output | GRP_W | Bus voltage reference command |

## Verification
Every 8-bit schedule is swept with several code layouts, floors and fail masks. This exposes a window that is one sample short or one sample long: such a design drops the reference below a string that is about to conduct, or holds a stale high value one cycle too long. The emptied schedule and the floor are checked directly, which catches a design that outputs zero in place of the floor or lets a low code beat the floor. Rotating a lone string and then forcing all strings on catches designs that sum or OR the codes where a maximum is required. Failed strings and fixed mode are also swept, which catches a failed string that still lifts the reference and a fixed mode that still follows the mask. A single nonzero code placed in one slot catches a misplaced field slice.

// File: rtl/busref_pkg.sv
package busref_pkg;

  typedef enum logic {
    MODE_TRACK = 1'b0,
    MODE_FIXED = 1'b1
  } ref_mode_e;

  function automatic ref_mode_e decode_mode(input logic fixed_bit);
    return fixed_bit ? MODE_FIXED : MODE_TRACK;
  endfunction

endpackage

// File: rtl/busref_window.sv
module busref_window #(
  parameter int NUM_STR   = 8,
  parameter int LOOKAHEAD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STR-1:0] sched_mask,
  output logic [NUM_STR-1:0] str_on,
  output logic [NUM_STR-1:0] window_mask
);

  localparam int LAST = LOOKAHEAD - 1;

  logic [NUM_STR-1:0] stage [LOOKAHEAD];

  // Delay line: stage[k] holds the schedule sampled k+1 edges ago.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LOOKAHEAD; k++) stage[k] <= '0;
    end else begin
      stage[0] <= sched_mask;
      for (int k = 1; k < LOOKAHEAD; k++) stage[k] <= stage[k-1];
    end
  end

  // Union of the incoming schedule and everything still in flight.
  always_comb begin
    window_mask = sched_mask;
    for (int k = 0; k < LOOKAHEAD; k++) window_mask = window_mask | stage[k];
  end

  assign str_on = stage[LAST];

endmodule

// File: rtl/busref_peak.sv
module busref_peak #(
  parameter int NUM_STR = 8,
  parameter int GRP_W   = 3
) (
  input  logic [NUM_STR-1:0]       sel_mask,
  input  logic [NUM_STR*GRP_W-1:0] codes,
  output logic [GRP_W-1:0]         peak,
  output logic                     any_sel
);

  logic [GRP_W-1:0] code_arr [NUM_STR];

  function automatic logic [GRP_W-1:0] wider(input logic [GRP_W-1:0] a,
                                             input logic [GRP_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  for (genvar g = 0; g < NUM_STR; g++) begin : g_unpack
    assign code_arr[g] = codes[g*GRP_W +: GRP_W];
  end

  always_comb begin
    peak    = '0;
    any_sel = 1'b0;
    for (int i = 0; i < NUM_STR; i++) begin
      if (sel_mask[i]) begin
        any_sel = 1'b1;
        peak    = wider(peak, code_arr[i]);
      end
    end
  end

endmodule

// File: rtl/busref_gen.sv
module busref_gen #(
  parameter int NUM_STR   = 8,
  parameter int GRP_W     = 3,
  parameter int LOOKAHEAD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_STR-1:0]       sched_mask,
  input  logic [NUM_STR*GRP_W-1:0] grp_codes,
  input  logic [NUM_STR-1:0]       fail_mask,
  input  logic [GRP_W-1:0]         floor_code,
  input  logic                     fixed_mode,
  output logic [NUM_STR-1:0]       str_on,
  output logic [GRP_W-1:0]         ref_code
);
  import busref_pkg::*;

  localparam int CODES_W = NUM_STR * GRP_W;

  ref_mode_e          mode;
  logic [NUM_STR-1:0] window_mask;
  logic [NUM_STR-1:0] healthy_mask;
  logic [NUM_STR-1:0] demand_mask;
  logic [GRP_W-1:0]   demand_peak;
  logic               demand_any;
  logic               demand_empty;
  logic [GRP_W-1:0]   next_ref;

  function automatic logic [GRP_W-1:0] lift_to_floor(input logic [GRP_W-1:0] pk,
                                                     input logic [GRP_W-1:0] fl);
    return (pk > fl) ? pk : fl;
  endfunction

  busref_window #(.NUM_STR(NUM_STR), .LOOKAHEAD(LOOKAHEAD)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .sched_mask (sched_mask),
    .str_on     (str_on),
    .window_mask(window_mask)
  );

  assign mode         = decode_mode(fixed_mode);
  assign healthy_mask = ~fail_mask;
  assign demand_mask  = (mode == MODE_FIXED) ? healthy_mask : (window_mask & healthy_mask);

  busref_peak #(.NUM_STR(NUM_STR), .GRP_W(GRP_W)) u_peak (
    .sel_mask(demand_mask),
    .codes   (grp_codes[CODES_W-1:0]),
    .peak    (demand_peak),
    .any_sel (demand_any)
  );

  assign demand_empty = ~demand_any;
  assign next_ref     = demand_empty ? floor_code : lift_to_floor(demand_peak, floor_code);

  always_ff @(posedge clk) begin
    if (!rst_n) ref_code <= '0;
    else        ref_code <= next_ref;
  end

endmodule

// File: rtl/busref_gen_chk.sv
module busref_gen_chk #(
  parameter int NUM_STR = 8,
  parameter int GRP_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_STR*GRP_W-1:0] grp_codes,
  input logic [NUM_STR-1:0]       fail_mask,
  input logic [GRP_W-1:0]         floor_code,
  input logic                     fixed_mode,
  input logic [NUM_STR-1:0]       str_on,
  input logic [GRP_W-1:0]         ref_code,
  input logic [NUM_STR-1:0]       demand_mask
);

  logic             seen;
  logic [GRP_W-1:0] on_peak;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    on_peak = '0;
    for (int i = 0; i < NUM_STR; i++)
      if (str_on[i] && !fail_mask[i] && grp_codes[i*GRP_W +: GRP_W] > on_peak)
        on_peak = grp_codes[i*GRP_W +: GRP_W];
  end

  assert_covers_conducting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $stable(grp_codes) && $stable(fail_mask)) |-> (ref_code >= on_peak));

  assert_empty_gives_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(demand_mask) == '0)) |-> (ref_code == $past(floor_code)));

  assert_fixed_ignores_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && fixed_mode && $past(fixed_mode) && $stable(grp_codes) &&
     $stable(fail_mask) && $stable(floor_code)) |=> $stable(ref_code));

  assert_never_below_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (ref_code >= $past(floor_code)));

endmodule

bind busref_gen busref_gen_chk #(.NUM_STR(NUM_STR), .GRP_W(GRP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grp_codes  (grp_codes),
  .fail_mask  (fail_mask),
  .floor_code (floor_code),
  .fixed_mode (fixed_mode),
  .str_on     (str_on),
  .ref_code   (ref_code),
  .demand_mask(demand_mask)
);

// File: tb/busref_gen_test.sv
module busref_gen_test;
  localparam int N = 8;
  localparam int W = 3;
  localparam int L = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   sched_mask;
  logic [N*W-1:0] grp_codes;
  logic [N-1:0]   fail_mask;
  logic [W-1:0]   floor_code;
  logic           fixed_mode;
  logic [N-1:0]   str_on;
  logic [W-1:0]   ref_code;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] hist [L+1];

  always #4 clk = ~clk;

  busref_gen #(.NUM_STR(N), .GRP_W(W), .LOOKAHEAD(L)) uut (
    .clk(clk), .rst_n(rst_n), .sched_mask(sched_mask), .grp_codes(grp_codes),
    .fail_mask(fail_mask), .floor_code(floor_code), .fixed_mode(fixed_mode),
    .str_on(str_on), .ref_code(ref_code)
  );

  function automatic int code_of(input int i);
    return int'(grp_codes[i*W +: W]);
  endfunction

  function automatic int top_code(input logic [N-1:0] m);
    int best = 0;
    for (int i = 0; i < N; i++)
      if (m[i] && !fail_mask[i] && code_of(i) > best) best = code_of(i);
    return best;
  endfunction

  function automatic int model_ref();
    logic [N-1:0] u = '0;
    int pk;
    for (int k = 0; k <= L; k++) u = u | hist[k];
    pk = fixed_mode ? top_code('1) : top_code(u);
    return (pk > int'(floor_code)) ? pk : int'(floor_code);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] m, input string tag);
    int e;
    int lo;
    sched_mask = m;
    @(posedge clk);
    for (int k = L; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = m;
    e  = model_ref();
    lo = top_code(hist[L-1]);
    @(negedge clk);
    check(tag, int'(ref_code), e);
    check("R2", int'(str_on), int'(hist[L-1]));
    check("R4", int'(ref_code >= W'(lo)), 1);
  endtask

  task automatic hold(input logic [N-1:0] m, input string tag);
    for (int k = 0; k <= L; k++) apply(m, tag);
  endtask

  task automatic set_codes(input int mul, input int add);
    for (int i = 0; i < N; i++) grp_codes[i*W +: W] = W'((i*mul + add) % (1 << W));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k <= L; k++) hist[k] = '0;
    rst_n = 1'b0; sched_mask = '1; fail_mask = '0; floor_code = 3'd3; fixed_mode = 1'b0;
    set_codes(5, 3);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R1", int'(ref_code), 0);
      check("R1", int'(str_on), 0);
    end
    sched_mask = '0; floor_code = '0;
    rst_n = 1'b1;

    // R3: every schedule, two code layouts
    for (int m = 0; m < (1 << N); m++) apply(N'(m), "R3");
    set_codes(3, 1);
    for (int m = 0; m < (1 << N); m++) apply(N'((m * 37) % 256), "R3");
    set_codes(5, 3);
    hold('0, "R7");
    check("R7", int'(ref_code), 0);

    // R10: floor raised
    floor_code = 3'd4;
    for (int m = 0; m < (1 << N); m++) apply(N'(m), "R10");
    hold('0, "R7");
    check("R7", int'(ref_code), 4);
    hold(8'h02, "R10");
    check("R10", int'(ref_code), 4);
    floor_code = '0;

    // R5: lone string rotation
    for (int s = 0; s < N; s++) begin
      hold(N'(1) << s, "R5");
      check("R5", int'(ref_code), code_of(s));
    end

    // R6: all strings on continuously
    hold('1, "R6");
    for (int c = 0; c < 5; c++) begin
      apply('1, "R6");
      check("R6", int'(ref_code), 7);
    end

    // R8: failed strings 4 (code 7) and 7 (code 6)
    fail_mask = 8'h90;
    hold('1, "R8");
    check("R8", int'(ref_code), 5);
    for (int m = 0; m < (1 << N); m++) apply(N'(m), "R8");
    hold(8'h10, "R8");
    check("R8", int'(ref_code), 0);

    // R9: fixed mode
    fail_mask = '0; fixed_mode = 1'b1;
    for (int m = 0; m < (1 << N); m++) begin
      apply(N'(m), "R9");
      check("R9", int'(ref_code), 7);
    end
    fail_mask = 8'h90; floor_code = 3'd2;
    for (int m = 0; m < 64; m++) begin
      apply(N'(m * 4), "R9");
      check("R9", int'(ref_code), 5);
    end
    fixed_mode = 1'b0; fail_mask = '0; floor_code = '0;

    // R11: single nonzero slot
    grp_codes = '0;
    grp_codes[5*W +: W] = 3'd6;
    hold(8'h20, "R11");
    check("R11", int'(ref_code), 6);
    hold(8'h04, "R11");
    check("R11", int'(ref_code), 0);
    hold(8'hDF, "R11");
    check("R11", int'(ref_code), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule